// File: doc/BRIEF.md
# Timed Interrupt Hold Gate

This block stops interrupt requests from being accepted for a programmed number of instruction cycles once a "hold interrupts" instruction executes. An instruction-valid strobe, a per-cycle enable and a decoded hold command with a count operand arrive each clock. The hold command is taken only when the instruction is valid and the cycle is enabled. The cycle that carries the command is blocked. So are the N enabled cycles after it, where N is the operand. A hold window therefore lasts N+1 instruction cycles.

Each interrupt lane carries a request bit and a priority level. The gate forwards a lane to the downstream arbiter through a registered output vector. It drops maskable lanes while a window is open. Top-level (non-maskable-class) lanes always pass. Level-0 lanes are never forwarded. A status flag shows that a window is still open after the command cycle. A software write can clear the counter and close the window early.

A new command always reloads the counter, whether the old window is running or has just ended, and masking carries on without a one-cycle gap. This includes the cycle in which the count has just reached zero.

Top module: `intr_hold_gate`

## Requirements
- R1: A hold command (instr_valid, cyc_en and hold_cmd all high at a clock edge) with operand N blocks maskable lanes in its own cycle and in the N following enabled cycles. An operand of 0 blocks exactly one cycle.
- R2: After a command, hold_active is high while the count is nonzero. The count starts at N and falls by one on each enabled cycle. hold_active goes low on the edge where the count reaches zero. The full 14-bit operand 16383 gives a 16384-cycle window.
- R3: A command taken while a window is open reloads the count with its own operand, and maskable lanes stay blocked with no gap.
- R4: A command taken in the first cycle after the count has reached zero blocks that cycle and starts a new window. The next cycle is blocked as well whenever the new operand is nonzero.
- R5: In a cycle with cyc_en low, the count and hold_active keep their values and no command is taken. In a cycle with instr_valid low, no command is taken.
- R6: The lane priority is 3 bits wide, and lane i uses irq_prio[3i+2:3i]. Level 7 is forwarded whenever it is requested. Level 0 is never forwarded. Levels 1 to 6 are forwarded only when the cycle is not blocked.
- R7: A high clr_wr clears the count, so hold_active is low after that edge. A command in the same cycle takes precedence over the clear.
- R8: A synchronous active-high rst clears the count, hold_active and irq_out.
- R9: irq_out is registered: the value after an edge comes from irq_req, irq_prio and the blocking state of the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| cyc_en | input | 1 | Instruction-cycle enable; low marks a stalled cycle |
| hold_cmd | input | 1 | Decoded hold-interrupts command |
| hold_cnt | input | CNT_W (14) | Count operand N of the command |
| clr_wr | input | 1 | Software write that clears the counter |
| irq_req | input | NUM_IRQ (8) | Pending request per lane |
| irq_prio | input | NUM_IRQ*PRIO_W (24) | Priority per lane; lane i at bits [3i+2:3i] |
| irq_out | output | NUM_IRQ (8) | Registered, gated request vector |
| hold_active | output | 1 | Window still open after the command cycle |

## Verification
Two things can meet in one cycle: the counter reaching zero and a fresh hold command arriving. The bench lets a window run out and then issues a command in exactly that first idle cycle. It also reloads in the last open cycle, and pairs a clear write with a command in the same cycle. A scoreboard model of the window, built from the requirements, predicts every cycle of irq_out and hold_active, so a single unblocked cycle at the hand-over shows up as a mismatch on the maskable lanes.

// File: rtl/intr_hold_pkg.sv
package intr_hold_pkg;

  typedef enum logic [1:0] {
    LANE_OFF      = 2'd0,
    LANE_MASKABLE = 2'd1,
    LANE_NMI      = 2'd2
  } lane_class_e;

  // Classify a priority level; top_level is the highest encodable level.
  function automatic lane_class_e classify(input logic [7:0] prio, input logic [7:0] top_level);
    if (prio == top_level)  return LANE_NMI;
    else if (prio == 8'd0)  return LANE_OFF;
    else                    return LANE_MASKABLE;
  endfunction

endpackage

// File: rtl/hold_counter.sv
module hold_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      cnt_q    <= load_val;
      active_q <= |load_val;
    end else if (clear) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (step && active_q) begin
      cnt_q    <= cnt_q - ONE;
      active_q <= (cnt_q != ONE);
    end
  end

endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import intr_hold_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      block,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  output logic [NUM_IRQ-1:0]        irq_out
);

  localparam logic [7:0] TOP_LVL = 8'((1 << PRIO_W) - 1);

  logic [NUM_IRQ-1:0] pass_d;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_lane
    lane_class_e cls;
    assign cls = classify(8'(irq_prio[g*PRIO_W +: PRIO_W]), TOP_LVL);
    always_comb begin
      unique case (cls)
        LANE_NMI:      pass_d[g] = irq_req[g];
        LANE_MASKABLE: pass_d[g] = irq_req[g] & ~block;
        default:       pass_d[g] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= pass_d;
  end

endmodule

// File: rtl/intr_hold_gate.sv
module intr_hold_gate #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      instr_valid,
  input  logic                      cyc_en,
  input  logic                      hold_cmd,
  input  logic [CNT_W-1:0]          hold_cnt,
  input  logic                      clr_wr,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  output logic [NUM_IRQ-1:0]        irq_out,
  output logic                      hold_active
);

  logic             cmd_fire;
  logic             block_now;
  logic [CNT_W-1:0] cnt_q;

  assign cmd_fire  = instr_valid & cyc_en & hold_cmd;
  assign block_now = cmd_fire | hold_active;

  hold_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (cyc_en),
    .load     (cmd_fire),
    .load_val (hold_cnt),
    .clear    (clr_wr),
    .cnt_q    (cnt_q),
    .active_q (hold_active)
  );

  prio_gate #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .block    (block_now),
    .irq_req  (irq_req),
    .irq_prio (irq_prio),
    .irq_out  (irq_out)
  );

endmodule

// File: rtl/intr_hold_gate_chk.sv
module intr_hold_gate_chk #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cyc_en,
  input logic                      hold_cmd,
  input logic                      instr_valid,
  input logic [CNT_W-1:0]          hold_cnt,
  input logic                      clr_wr,
  input logic [NUM_IRQ-1:0]        irq_req,
  input logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input logic [NUM_IRQ-1:0]        irq_out,
  input logic                      hold_active,
  input logic [CNT_W-1:0]          cnt_q
);

  localparam logic [PRIO_W-1:0] TOP = PRIO_W'((1 << PRIO_W) - 1);

  logic fire;
  logic [NUM_IRQ-1:0] maskable;
  assign fire = instr_valid & cyc_en & hold_cmd;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
    logic [PRIO_W-1:0] p;
    assign p = irq_prio[g*PRIO_W +: PRIO_W];
    assign maskable[g] = (p != '0) && (p != TOP);

    a_r6_top_passes: assert property (@(posedge clk) disable iff (rst)
      (irq_req[g] && p == TOP) |=> irq_out[g]);
    a_r6_zero_dropped: assert property (@(posedge clk) disable iff (rst)
      (p == '0) |=> !irq_out[g]);
  end

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q == $past(hold_cnt)) && (hold_active == ($past(hold_cnt) != '0)));

  a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
    (hold_active && cyc_en && !fire && !clr_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  a_r3_blocked: assert property (@(posedge clk) disable iff (rst)
    (fire || hold_active) |=> ((irq_out & $past(maskable)) == '0));

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (!cyc_en && !clr_wr) |=> ($stable(cnt_q) && $stable(hold_active)));

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !fire) |=> (!hold_active && cnt_q == '0));

endmodule

bind intr_hold_gate intr_hold_gate_chk #(
  .CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .hold_cmd(hold_cmd),
  .instr_valid(instr_valid), .hold_cnt(hold_cnt), .clr_wr(clr_wr),
  .irq_req(irq_req), .irq_prio(irq_prio), .irq_out(irq_out),
  .hold_active(hold_active), .cnt_q(cnt_q)
);

// File: tb/test_intr_hold_gate.sv
module test_intr_hold_gate;

  localparam int CNT_W = 14, NUM_IRQ = 8, PRIO_W = 3;

  logic clk = 1'b0;
  logic rst, instr_valid, cyc_en, hold_cmd, clr_wr;
  logic [CNT_W-1:0] hold_cnt;
  logic [NUM_IRQ-1:0] irq_req, irq_out;
  logic [NUM_IRQ*PRIO_W-1:0] irq_prio;
  logic hold_active;

  always #4 clk = ~clk;

  intr_hold_gate #(.CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_intr_hold_gate (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .cyc_en(cyc_en),
    .hold_cmd(hold_cmd), .hold_cnt(hold_cnt), .clr_wr(clr_wr),
    .irq_req(irq_req), .irq_prio(irq_prio), .irq_out(irq_out),
    .hold_active(hold_active)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [NUM_IRQ-1:0] q_out[$];
  logic q_act[$];
  string q_tag[$];

  // reference model state
  int rem = 0;
  bit act = 0;

  // lane i priority 7-i: lane0 top level, lane7 level 0
  localparam logic [NUM_IRQ*PRIO_W-1:0] PRIO_A = {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7};
  localparam logic [NUM_IRQ*PRIO_W-1:0] PRIO_B = {3'd7,3'd7,3'd0,3'd2,3'd5,3'd0,3'd1,3'd6};

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(input bit r, input bit iv, input bit ce, input bit cmd,
                      input int n, input bit clr, input logic [NUM_IRQ-1:0] req,
                      input logic [NUM_IRQ*PRIO_W-1:0] pr, input string tag);
    bit fire, blk;
    logic [NUM_IRQ-1:0] eo;
    @(negedge clk);
    rst = r; instr_valid = iv; cyc_en = ce; hold_cmd = cmd;
    hold_cnt = CNT_W'(n); clr_wr = clr; irq_req = req; irq_prio = pr;
    fire = iv && ce && cmd;
    blk  = fire || act;
    for (int i = 0; i < NUM_IRQ; i++) begin
      int p = int'(pr[i*PRIO_W +: PRIO_W]);
      if (p == 7)      eo[i] = req[i];
      else if (p == 0) eo[i] = 1'b0;
      else             eo[i] = req[i] && !blk;
    end
    if (r) begin
      rem = 0; act = 0; eo = '0;
    end else if (fire) begin
      rem = n; act = (n != 0);
    end else if (clr) begin
      rem = 0; act = 0;
    end else if (ce && act) begin
      rem = rem - 1; act = (rem != 0);
    end
    q_out.push_back(eo);
    q_act.push_back(act);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) step(0, 1, 1, 0, 0, 0, 8'hFF, PRIO_A, tag);
  endtask

  task automatic hold(input int n, input string tag);
    step(0, 1, 1, 1, n, 0, 8'hFF, PRIO_A, tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (q_tag.size() > 0) begin
      logic [NUM_IRQ-1:0] eo;
      logic ea;
      string t;
      eo = q_out.pop_front(); ea = q_act.pop_front(); t = q_tag.pop_front();
      n_chk += 2;
      if (irq_out !== eo) begin
        n_fail++;
        $display("FAIL %s irq_out actual=%h expected=%h at %0t", t, irq_out, eo, $time);
      end
      if (hold_active !== ea) begin
        n_fail++;
        $display("FAIL %s hold_active actual=%b expected=%b at %0t", t, hold_active, ea, $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst = 1; instr_valid = 0; cyc_en = 0; hold_cmd = 0; hold_cnt = '0;
    clr_wr = 0; irq_req = '0; irq_prio = '0;
    // R8 reset state
    step(1, 0, 0, 0, 0, 0, 8'hFF, PRIO_A, "R8");
    step(1, 1, 1, 1, 5, 0, 8'hFF, PRIO_A, "R8");
    // R6 / R9 pass-through with different patterns
    idle(1, "R6");
    step(0, 1, 1, 0, 0, 0, 8'hA5, PRIO_B, "R9");
    step(0, 0, 1, 0, 0, 0, 8'h5A, PRIO_B, "R9");
    step(0, 1, 0, 0, 0, 0, 8'h3C, PRIO_A, "R6");
    // R1 operand 0 blocks one cycle
    hold(0, "R1"); idle(2, "R1");
    // R1/R2 operand 3
    hold(3, "R2"); idle(5, "R2");
    // R4 command on the cycle the count has reached zero
    hold(2, "R4"); idle(2, "R4");
    hold(1, "R4"); idle(3, "R4");
    hold(2, "R4"); idle(2, "R4");
    hold(0, "R4"); idle(2, "R4");
    // R3 reload in the last open cycle and mid-window
    hold(2, "R3"); idle(1, "R3"); hold(3, "R3"); idle(5, "R3");
    hold(5, "R3"); idle(1, "R3"); hold(1, "R3"); idle(3, "R3");
    // R5 stalls and invalid instruction
    hold(2, "R5");
    step(0, 1, 0, 0, 0, 0, 8'hFF, PRIO_A, "R5");
    step(0, 1, 0, 1, 9, 0, 8'hFF, PRIO_B, "R5");
    step(0, 0, 0, 0, 0, 0, 8'hFF, PRIO_A, "R5");
    idle(3, "R5");
    step(0, 0, 1, 1, 4, 0, 8'hFF, PRIO_A, "R5");
    idle(2, "R5");
    // R7 clear, then clear together with command
    hold(5, "R7"); idle(1, "R7");
    step(0, 1, 1, 0, 0, 1, 8'hFF, PRIO_A, "R7");
    idle(2, "R7");
    hold(2, "R7");
    step(0, 1, 1, 1, 4, 1, 8'hFF, PRIO_A, "R7");
    idle(6, "R7");
    // R8 reset mid-window
    hold(6, "R8"); idle(1, "R8");
    step(1, 1, 1, 0, 0, 0, 8'hFF, PRIO_A, "R8");
    idle(2, "R8");
    // R2 full-width operand
    hold(16383, "R2");
    idle(16386, "R2");
    @(negedge clk); @(negedge clk);
    finish_up();
  end

endmodule